// File: doc/BRIEF.md
# Tamper Event Latch and Security Violation Controller

This block collects ten tamper and alarm sources into sticky status bits and runs the security state of the secure real-time clock domain. Each source arrives as a single-cycle pulse and is latched whether or not it is enabled. When an enabled source fires, the block enters a violation state. It also marks the time as non-valid and withdraws the enable of the time counter.

Firmware restores service through a fixed recovery order. It first clears every latched source. Only then may it clear the violation flag. Clearing the non-valid flag comes last. Lock bits can freeze the tamper configuration and block recovery steps, and an interrupt follows the violation flag.

The security state is held in a four-state machine whose code is the pair {non-valid, violation}:
- `ST_VALID` (00)
- `ST_FAILURE` (01)
- `ST_INVALID` (10)
- `ST_FAIL_INV` (11)

The transitions are as follows:
- **trip**: from any state to `ST_FAIL_INV`, on an enabled event.
- **revalidate**: from `ST_INVALID` to `ST_VALID`, when the non-valid flag is cleared.
- **keep_fail**: from `ST_FAIL_INV` to `ST_FAILURE`, when the non-valid flag is cleared.
- **recover**: from `ST_FAILURE` or `ST_FAIL_INV` to `ST_INVALID`, when the violation flag is cleared and the clear is permitted.

Reset enters `ST_INVALID`.

Top module: `tamper_guard`

## Requirements
- R1: After reset, the following hold:
  - `state_o` is 2'b10 and `status_o` is 32'h2.
  - `tamper_en_o`, `ctrl_o`, `cnt_en_o`, `irq_o` and `wr_err_o` are all zero.
- R2: A pulse on `evt_i[k]` sets its status bit one cycle later, even when `tamper_en_o[k]` is 0; a disabled event leaves `state_o` unchanged.
  - Status bit positions are: k=0..7 at bits 16..23, k=8 at bit 2, k=9 at bit 3.
  - Bit 0 is the violation flag and bit 1 is the non-valid flag.
- R3: A pulse on `evt_i[k]` with `tamper_en_o[k]`=1 moves `state_o` to 2'b11 on the next cycle, sets `viol_o`, and clears `cnt_en_o`.
- R4: A write to the status word (`wr_sel_i`=1) clears each source bit written as 1 and leaves bits written as 0. An event in the same cycle as the clear of its bit keeps the bit set.
- R5: Writing 1 to status bit 0 is refused while any source bit is latched. Otherwise, it moves `ST_FAILURE` or `ST_FAIL_INV` to `ST_INVALID`. A same-cycle enabled event keeps the state at 2'b11.
- R6: Writing 1 to status bit 1 moves `ST_INVALID` to `ST_VALID` and `ST_FAIL_INV` to `ST_FAILURE` (2'b01).
- R7: The control word is written with `wr_sel_i`=2.
  - Control bits 29 and 30 are set-only locks; no write can clear them.
  - While either lock is set, writes to the tamper-enable word (`wr_sel_i`=0) are refused.
  - While bit 30 is set, source-bit clears are refused.
- R8: Control bit 16 is a set-only lock; while it is set, clearing the violation flag is refused.
- R9: While the violation flag is set, the following hold:
  - `tcnt_wr_ok_o` stays 0 even when `tcnt_wr_i` is raised.
  - Writing 1 to control bit 3 (time-counter enable, mirrored on `cnt_en_o`) leaves `cnt_en_o` at 0.
- R10: `irq_o` equals the violation flag ANDed with bit 0 of the interrupt-enable word (`wr_sel_i`=3).
- R11: Every refused write raises `wr_err_o` for exactly one cycle, on the cycle after the write. Refused writes are those of R5, R7, R8 and R9, including a refused `tcnt_wr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | Single-cycle tamper/alarm event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Word select: 0 enable, 1 status, 2 control, 3 interrupt enable |
| wr_data_i | input | 32 | Write data |
| tcnt_wr_i | input | 1 | Request to write the time counter |
| tamper_en_o | output | 10 | Tamper-enable word |
| status_o | output | 32 | Status word |
| ctrl_o | output | 32 | Control word (bits 3, 16, 29, 30) |
| viol_o | output | 1 | Security violation flag |
| cnt_en_o | output | 1 | Time-counter enable (low requests counter disable) |
| tcnt_wr_ok_o | output | 1 | Time-counter write granted |
| wr_err_o | output | 1 | Write-refused pulse |
| irq_o | output | 1 | Violation interrupt |
| state_o | output | 2 | Security state {non-valid, violation} |

## Verification
Two pairs of functions can collide in a single cycle. The first is an event pulse and a write-1 clear of that same source bit. The second is an enabled event and a write that clears the violation flag once the sources are empty. The bench drives both the pulse and the write strobe within one clock period. It then judges that the event wins: the source bit stays set, and the state remains 2'b11 instead of falling to 2'b10.

// File: rtl/tamper_guard_pkg.sv
package tamper_guard_pkg;
    localparam int NSRC      = 10;
    localparam int DATA_W    = 32;
    localparam int SVF_BIT   = 0;
    localparam int NVF_BIT   = 1;
    localparam int CNTEN_BIT = 3;
    localparam int FLOCK_BIT = 16;
    localparam int SLOCK_BIT = 29;
    localparam int HLOCK_BIT = 30;

    typedef enum logic [1:0] {
        ST_VALID    = 2'b00,
        ST_FAILURE  = 2'b01,
        ST_INVALID  = 2'b10,
        ST_FAIL_INV = 2'b11
    } guard_state_e;

    // status-word position of each source (firmware decodes these)
    function automatic int src_pos(input int idx);
        if (idx < 8)
            return 16 + idx;
        else if (idx == 8)
            return 2;
        else
            return 3;
    endfunction
endpackage

// File: rtl/src_latch.sv
module src_latch #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i[i])
                q_o[i] <= 1'b0;
        end

        // R4: an arriving event beats a same-cycle clear
        p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
    end
endmodule

// File: rtl/viol_fsm.sv
module viol_fsm
    import tamper_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trip_i,
    input  logic         clr_svf_i,
    input  logic         clr_nvf_i,
    input  logic         src_any_i,
    input  logic         fail_lock_i,
    output guard_state_e state_o,
    output logic         svf_o,
    output logic         nvf_o
);
    guard_state_e state_q, state_d;
    logic         svf_clear_ok;

    assign svf_clear_ok = clr_svf_i && !src_any_i && !fail_lock_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_INVALID;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (trip_i) begin
            state_d = ST_FAIL_INV;
        end else begin
            unique case (state_q)
                ST_VALID:    state_d = ST_VALID;
                ST_INVALID:  if (clr_nvf_i) state_d = ST_VALID;
                ST_FAILURE:  if (svf_clear_ok) state_d = ST_INVALID;
                ST_FAIL_INV: begin
                    if (svf_clear_ok)
                        state_d = ST_INVALID;
                    else if (clr_nvf_i)
                        state_d = ST_FAILURE;
                end
                default:     state_d = ST_FAIL_INV;
            endcase
        end
    end

    always_comb begin
        state_o = state_q;
        svf_o   = 1'b0;
        nvf_o   = 1'b0;
        unique case (state_q)
            ST_VALID:    ;
            ST_FAILURE:  svf_o = 1'b1;
            ST_INVALID:  nvf_o = 1'b1;
            ST_FAIL_INV: begin svf_o = 1'b1; nvf_o = 1'b1; end
            default:     begin svf_o = 1'b1; nvf_o = 1'b1; end
        endcase
    end

    p_trip_fail_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> (state_q == ST_FAIL_INV));
    p_clear_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (svf_o && clr_svf_i && src_any_i) |=> svf_o);
    p_flock_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (svf_o && fail_lock_i) |=> svf_o);
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
    import tamper_guard_pkg::*;
#(
    parameter int NUM_SRC = NSRC,
    parameter int DW      = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [DW-1:0]      wr_data_i,
    input  logic               tcnt_wr_i,
    output logic [NUM_SRC-1:0] tamper_en_o,
    output logic [DW-1:0]      status_o,
    output logic [DW-1:0]      ctrl_o,
    output logic               viol_o,
    output logic               cnt_en_o,
    output logic               tcnt_wr_ok_o,
    output logic               wr_err_o,
    output logic               irq_o,
    output logic [1:0]         state_o
);
    localparam logic [1:0] SEL_EN   = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_IRQ  = 2'd3;

    logic [NUM_SRC-1:0] en_q, src_q, clr_raw, clr_ok;
    logic               irqen_q, cnt_en_q, flock_q, slock_q, hlock_q, err_q;
    logic               wr_en_w, wr_stat, wr_ctrl, wr_irq, trip, src_any;
    logic               svf, nvf, err_d;
    guard_state_e       st;
    logic               unused_bits;

    assign unused_bits = ^wr_data_i;
    assign wr_en_w = wr_en_i && (wr_sel_i == SEL_EN);
    assign wr_stat = wr_en_i && (wr_sel_i == SEL_STAT);
    assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign wr_irq  = wr_en_i && (wr_sel_i == SEL_IRQ);

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            clr_raw[i] = wr_data_i[src_pos(i)];
    end
    assign clr_ok  = (wr_stat && !hlock_q) ? clr_raw : '0;
    assign trip    = |(evt_i & en_q);
    assign src_any = |src_q;

    src_latch #(.N(NUM_SRC)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_i),
        .clr_i (clr_ok),
        .q_o   (src_q)
    );

    viol_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip_i      (trip),
        .clr_svf_i   (wr_stat && wr_data_i[SVF_BIT]),
        .clr_nvf_i   (wr_stat && wr_data_i[NVF_BIT]),
        .src_any_i   (src_any),
        .fail_lock_i (flock_q),
        .state_o     (st),
        .svf_o       (svf),
        .nvf_o       (nvf)
    );

    always_comb begin
        err_d = 1'b0;
        if (wr_en_w && (slock_q || hlock_q))
            err_d = 1'b1;
        if (wr_stat && hlock_q && |clr_raw)
            err_d = 1'b1;
        if (wr_stat && wr_data_i[SVF_BIT] && svf && (src_any || flock_q))
            err_d = 1'b1;
        if (wr_ctrl && wr_data_i[CNTEN_BIT] && svf)
            err_d = 1'b1;
        if (tcnt_wr_i && svf)
            err_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            irqen_q  <= 1'b0;
            cnt_en_q <= 1'b0;
            flock_q  <= 1'b0;
            slock_q  <= 1'b0;
            hlock_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= err_d;
            if (wr_en_w && !slock_q && !hlock_q)
                en_q <= wr_data_i[NUM_SRC-1:0];
            if (wr_irq)
                irqen_q <= wr_data_i[0];
            if (trip)
                cnt_en_q <= 1'b0;
            else if (wr_ctrl && !(wr_data_i[CNTEN_BIT] && svf))
                cnt_en_q <= wr_data_i[CNTEN_BIT];
            if (wr_ctrl) begin
                flock_q <= flock_q | wr_data_i[FLOCK_BIT];
                slock_q <= slock_q | wr_data_i[SLOCK_BIT];
                hlock_q <= hlock_q | wr_data_i[HLOCK_BIT];
            end
        end
    end

    always_comb begin
        status_o = '0;
        for (int i = 0; i < NUM_SRC; i++)
            status_o[src_pos(i)] = src_q[i];
        status_o[SVF_BIT] = svf;
        status_o[NVF_BIT] = nvf;
        ctrl_o = '0;
        ctrl_o[CNTEN_BIT] = cnt_en_q;
        ctrl_o[FLOCK_BIT] = flock_q;
        ctrl_o[SLOCK_BIT] = slock_q;
        ctrl_o[HLOCK_BIT] = hlock_q;
    end

    assign tamper_en_o  = en_q;
    assign viol_o       = svf;
    assign cnt_en_o     = cnt_en_q;
    assign tcnt_wr_ok_o = tcnt_wr_i && !svf;
    assign wr_err_o     = err_q;
    assign irq_o        = svf && irqen_q;
    assign state_o      = st;

    p_cnt_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svf |-> !cnt_en_q);
    p_tcnt_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tcnt_wr_i && svf) |=> wr_err_o);
    p_locks_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hlock_q |=> hlock_q);
endmodule

// File: tb/tamper_guard_test.sv
module tamper_guard_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        tcnt_wr_i = 1'b0;
    logic [9:0]  tamper_en_o;
    logic [31:0] status_o, ctrl_o;
    logic        viol_o, cnt_en_o, tcnt_wr_ok_o, wr_err_o, irq_o;
    logic [1:0]  state_o;
    int          checks = 0;
    int          errors = 0;

    always #(PERIOD/2) clk = ~clk;

    tamper_guard uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .tcnt_wr_i(tcnt_wr_i),
        .tamper_en_o(tamper_en_o), .status_o(status_o), .ctrl_o(ctrl_o),
        .viol_o(viol_o), .cnt_en_o(cnt_en_o), .tcnt_wr_ok_o(tcnt_wr_ok_o),
        .wr_err_o(wr_err_o), .irq_o(irq_o), .state_o(state_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; outputs are sampled at the following negedge
    task automatic cyc(input logic we, input logic [1:0] sel, input logic [31:0] d,
                       input logic [9:0] ev);
        wr_en_i = we; wr_sel_i = sel; wr_data_i = d; evt_i = ev;
        @(negedge clk);
        wr_en_i = 1'b0; evt_i = '0; wr_data_i = '0;
    endtask

    task automatic t_reset;
        chk({30'd0, state_o}, 32'h2, "R1 state");
        chk(status_o, 32'h2, "R1 status");
        chk({22'd0, tamper_en_o}, 32'h0, "R1 enable");
        chk(ctrl_o, 32'h0, "R1 ctrl");
        chk({28'd0, cnt_en_o, irq_o, wr_err_o, viol_o}, 32'h0, "R1 flags");
    endtask

    task automatic t_latch;
        cyc(1'b0, 2'd0, 32'h0, 10'h001);
        chk(status_o, 32'h0001_0002, "R2 src0 latched while disabled");
        chk({30'd0, state_o}, 32'h2, "R2 disabled event keeps state");
        cyc(1'b0, 2'd0, 32'h0, 10'h300);
        chk(status_o, 32'h0001_000E, "R2 src8/src9 positions");
    endtask

    task automatic t_clear;
        cyc(1'b1, 2'd1, 32'h0001_0000, 10'h0);
        chk(status_o, 32'h0000_000E, "R4 w1c bit16");
        cyc(1'b1, 2'd1, 32'h0, 10'h0);
        chk(status_o, 32'h0000_000E, "R4 zero write no effect");
        cyc(1'b1, 2'd1, 32'h0000_0004, 10'h100);
        chk(status_o, 32'h0000_000E, "R4 event beats clear");
        cyc(1'b1, 2'd1, 32'h0000_000C, 10'h0);
        chk(status_o, 32'h0000_0002, "R4 clear ovf bits");
    endtask

    task automatic t_revalidate;
        cyc(1'b1, 2'd1, 32'h2, 10'h0);
        chk({30'd0, state_o}, 32'h0, "R6 invalid->valid");
        cyc(1'b1, 2'd2, 32'h8, 10'h0);
        chk({31'd0, cnt_en_o}, 32'h1, "R9 cnt enable allowed when valid");
        chk({31'd0, wr_err_o}, 32'h0, "R11 no error on legal write");
    endtask

    task automatic t_trip;
        cyc(1'b1, 2'd0, 32'h80, 10'h0);
        chk({22'd0, tamper_en_o}, 32'h80, "R7 enable write unlocked");
        cyc(1'b0, 2'd0, 32'h0, 10'h080);
        chk(status_o, 32'h0080_0003, "R3 status after trip");
        chk({30'd0, state_o}, 32'h3, "R3 state fail+inv");
        chk({30'd0, viol_o, cnt_en_o}, 32'h2, "R3 viol set cnt cleared");
    endtask

    task automatic t_irq;
        chk({31'd0, irq_o}, 32'h0, "R10 irq masked");
        cyc(1'b1, 2'd3, 32'h1, 10'h0);
        chk({31'd0, irq_o}, 32'h1, "R10 irq enabled");
    endtask

    task automatic t_refuse;
        tcnt_wr_i = 1'b1;
        #1;
        chk({31'd0, tcnt_wr_ok_o}, 32'h0, "R9 tcnt write blocked");
        @(negedge clk);
        tcnt_wr_i = 1'b0;
        chk({31'd0, wr_err_o}, 32'h1, "R11 tcnt refusal error");
        cyc(1'b1, 2'd2, 32'h8, 10'h0);
        chk({31'd0, cnt_en_o}, 32'h0, "R9 cnt enable refused");
        chk({31'd0, wr_err_o}, 32'h1, "R11 cnt enable error");
        @(negedge clk);
        chk({31'd0, wr_err_o}, 32'h0, "R11 error is one cycle");
    endtask

    task automatic t_recover;
        cyc(1'b1, 2'd1, 32'h1, 10'h0);
        chk({30'd0, state_o}, 32'h3, "R5 clear refused with source");
        chk({31'd0, wr_err_o}, 32'h1, "R5 refusal error");
        cyc(1'b1, 2'd1, 32'h0080_0000, 10'h0);
        chk(status_o, 32'h3, "R4 source cleared");
        cyc(1'b1, 2'd1, 32'h1, 10'h080);
        chk({30'd0, state_o}, 32'h3, "R5 event beats violation clear");
        cyc(1'b1, 2'd1, 32'h0080_0000, 10'h0);
        cyc(1'b1, 2'd1, 32'h2, 10'h0);
        chk({30'd0, state_o}, 32'h1, "R6 fail+inv->failure");
        cyc(1'b1, 2'd1, 32'h1, 10'h0);
        chk({30'd0, state_o}, 32'h2, "R5 failure->invalid");
        chk({31'd0, irq_o}, 32'h0, "R10 irq drops");
    endtask

    task automatic t_locks;
        cyc(1'b1, 2'd2, 32'h2000_0000, 10'h0);
        cyc(1'b1, 2'd0, 32'h3FF, 10'h0);
        chk({22'd0, tamper_en_o}, 32'h80, "R7 soft lock blocks enable");
        chk({31'd0, wr_err_o}, 32'h1, "R11 soft lock error");
        cyc(1'b1, 2'd2, 32'h0001_0000, 10'h0);
        cyc(1'b0, 2'd0, 32'h0, 10'h080);
        cyc(1'b1, 2'd1, 32'h0080_0000, 10'h0);
        cyc(1'b1, 2'd1, 32'h1, 10'h0);
        chk({31'd0, viol_o}, 32'h1, "R8 failure lock blocks clear");
        chk({31'd0, wr_err_o}, 32'h1, "R8 failure lock error");
        cyc(1'b1, 2'd2, 32'h4000_0000, 10'h0);
        cyc(1'b0, 2'd0, 32'h0, 10'h001);
        cyc(1'b1, 2'd1, 32'h0001_0000, 10'h0);
        chk(status_o & 32'h0001_0000, 32'h0001_0000, "R7 hard lock blocks clear");
        chk({31'd0, wr_err_o}, 32'h1, "R7 hard lock error");
        cyc(1'b1, 2'd2, 32'h0, 10'h0);
        chk(ctrl_o, 32'h6001_0000, "R7 R8 locks are set-only");
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_clear();
        t_revalidate();
        t_trip();
        t_irq();
        t_refuse();
        t_recover();
        t_locks();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule